// File: doc/BRIEF.md
# Bitmap Video Scanout Controller

This block turns a one-bit-per-pixel bitmap held in word-wide external memory into raster video. It keeps horizontal and vertical position with LFSR counters, not binary ones. Every position the block cares about (end of line, end of active area, start and end of sync) is found by comparing the LFSR state with a constant. These constants are computed at elaboration time from the position parameters. Each clock carries two pixels, so one 16-bit word covers eight clocks. The block reads one word per eight-clock slot of the active area over a valid/ready read port, then shifts it out two bits per clock.

Reads run one slot ahead of the picture. A word requested during slot k is shown during slot k+1. Blanking and both sync outputs are delayed by the same eight clocks, so they stay aligned with the pixels. The read address returns to a base value at the end of every frame and advances by one word per active slot.

Read port rules:
- `rd_valid` rises on the second clock of an active slot. `rd_addr` is held stable while `rd_valid` is high.
- The transfer completes on the first clock where `rd_valid` and `rd_ready` are both high. `rd_data` must be valid in that same clock.
- If no transfer has happened by the last clock of the slot, the request is withdrawn without a handshake. That slot is shown blank and a sticky underrun flag is raised.

The default raster suits a fixed 12 MHz clock:
- 384 clocks per line, of which 280 clocks (560 pixels) are active.
- 500 lines per frame, of which 455 are active.
- The bitmap is 15925 words, which fits in 32 KB.

Top module: `vscan_controller`

## Requirements
- R1: While reset is held and on the first clock after it, `pix_pair` is 0, `blank` is 1, `hsync` and `vsync` are 0, and `rd_valid` and `underrun` are 0.
- R2: A line lasts H_TOTAL clocks and its first H_ACTIVE clocks are active. `hsync` is high at line positions HS_ON to HS_OFF-1. All video outputs lag the internal position by WORD_W/2 clocks.
- R3: A frame lasts V_TOTAL lines and its first V_ACTIVE lines are active. `vsync` is high for the whole of lines VS_ON to VS_OFF-1, with the same lag as R2.
- R4: In each active slot, `rd_valid` is high from the slot's second clock until the clock with `rd_ready` high, or until the slot's last clock. It falls after a transfer, so at most one transfer happens per slot.
- R5: The first active slot of every frame reads address BASE. Each later active slot reads the previous address plus one, including a slot that ended without data.
- R6: A fetched word is shown in the eight clocks that start eight clocks after its slot began. It is shown most significant bits first: `pix_pair` = bits [15:14] first and bits [1:0] last. Bit 1 of `pix_pair` is the earlier pixel.
- R7: Outside the delayed active area, `blank` is 1 and `pix_pair` is 0. Inside it, `blank` is 0.
- R8: If a slot ends with no transfer, all eight pixel pairs shown for that slot are 0. `underrun` then goes to 1 and stays 1 until reset.
- R9: `rd_valid` stays low throughout slots that begin in horizontal or vertical blanking.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| rd_valid | output | 1 | Read request outstanding |
| rd_ready | input | 1 | Memory accepts the request and returns data in the same clock |
| rd_addr | output | ADDR_W | Word address of the request |
| rd_data | input | WORD_W | Read data, sampled when both valid and ready are high |
| pix_pair | output | 2 | Two pixels for this clock; bit 1 is the earlier pixel |
| blank | output | 1 | High outside the visible area |
| hsync | output | 1 | Horizontal sync pulse, active high |
| vsync | output | 1 | Vertical sync pulse, active high |
| underrun | output | 1 | Sticky flag: a slot ended without read data |

## Verification
The embedded properties assume the following:
- `rd_ready` is driven as a one-clock acceptance while a request is outstanding.
- The timing parameters keep both sync pulses inside blanking.
- H_TOTAL and H_ACTIVE are multiples of eight.

The stimulus keeps to these assumptions. It uses a reduced raster and a memory responder that raises ready for one clock, at an address-dependent latency, only while the modelled request is outstanding. In the second frame, one chosen address is given a latency longer than the slot, to produce a single underrun.

// File: rtl/vscan_pkg.sv
package vscan_pkg;

  // One Fibonacci LFSR step; w is the register width, taps marks feedback bits.
  function automatic logic [15:0] lfsr_next(input logic [15:0] s,
                                            input logic [15:0] taps,
                                            input int w);
    logic [15:0] mask;
    logic        fb;
    mask = 16'((32'd1 << w) - 32'd1);
    fb   = ^(s & taps);
    return 16'(((s << 1) | {15'd0, fb}) & mask);
  endfunction

  // State reached from the seed after n steps.
  function automatic logic [15:0] lfsr_at(input logic [15:0] taps,
                                          input int w,
                                          input int n);
    logic [15:0] s;
    s = 16'd1;
    for (int i = 0; i < n; i++) s = lfsr_next(s, taps, w);
    return s;
  endfunction

endpackage

// File: rtl/vscan_timer.sv
module vscan_timer #(
  parameter int          W        = 9,
  parameter logic [15:0] TAPS     = 16'h0110,
  parameter int          TOTAL    = 384,
  parameter int          ACTIVE   = 280,
  parameter int          SYNC_ON  = 296,
  parameter int          SYNC_OFF = 342
) (
  input  logic clk,
  input  logic rst_n,
  input  logic adv,
  output logic wrap,
  output logic active,
  output logic sync
);
  localparam logic [W-1:0] SEED    = W'(1);
  localparam logic [W-1:0] S_TERM  = W'(vscan_pkg::lfsr_at(TAPS, W, TOTAL - 1));
  localparam logic [W-1:0] S_AEND  = W'(vscan_pkg::lfsr_at(TAPS, W, ACTIVE - 1));
  localparam logic [W-1:0] S_SON   = W'(vscan_pkg::lfsr_at(TAPS, W, SYNC_ON - 1));
  localparam logic [W-1:0] S_SOFF  = W'(vscan_pkg::lfsr_at(TAPS, W, SYNC_OFF - 1));

  logic [W-1:0] state;

  assign wrap = adv && (state == S_TERM);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state  <= SEED;
      active <= 1'b1;
      sync   <= 1'b0;
    end else if (adv) begin
      state <= wrap ? SEED : W'(vscan_pkg::lfsr_next(16'(state), TAPS, W));
      if (wrap)                 active <= 1'b1;
      else if (state == S_AEND) active <= 1'b0;
      if (state == S_SON)       sync <= 1'b1;
      else if (state == S_SOFF) sync <= 1'b0;
    end
  end

  // R2
  sync_idle_at_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wrap |=> !sync);
  // R3
  sync_in_blank_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sync) |-> !active);

endmodule

// File: rtl/vscan_fetch.sv
module vscan_fetch #(
  parameter int WORD_W    = 16,
  parameter int ADDR_W    = 14,
  parameter int BASE      = 0,
  parameter int WORD_CLKS = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              line_wrap,
  input  logic              frame_end,
  input  logic              fetch_act,
  output logic              rd_valid,
  input  logic              rd_ready,
  output logic [ADDR_W-1:0] rd_addr,
  input  logic [WORD_W-1:0] rd_data,
  output logic              load,
  output logic [WORD_W-1:0] load_word,
  output logic              miss
);
  localparam int                PH_W    = (WORD_CLKS > 1) ? $clog2(WORD_CLKS) : 1;
  localparam logic [PH_W-1:0]   PH_LAST = PH_W'(WORD_CLKS - 1);
  localparam logic [ADDR_W-1:0] A_BASE  = ADDR_W'(BASE);

  logic [PH_W-1:0]   phase;
  logic              live, pend, got, take, slot_open, slot_end;
  logic [WORD_W-1:0] hold_q;
  logic [ADDR_W-1:0] addr_q;

  assign take      = pend && rd_ready;
  assign slot_open = fetch_act && (phase == '0);
  assign slot_end  = (phase == PH_LAST);

  always_ff @(posedge clk) begin
    if (!rst_n || line_wrap) phase <= '0;
    else                     phase <= phase + PH_W'(1);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      live   <= 1'b0;
      pend   <= 1'b0;
      got    <= 1'b0;
      hold_q <= '0;
    end else if (slot_end) begin
      live <= 1'b0;
      pend <= 1'b0;
      got  <= 1'b0;
    end else begin
      if (slot_open) begin
        live <= 1'b1;
        pend <= 1'b1;
      end
      if (take) begin
        pend   <= 1'b0;
        got    <= 1'b1;
        hold_q <= rd_data;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n || frame_end) addr_q <= A_BASE;
    else if (slot_end && live) addr_q <= addr_q + ADDR_W'(1);
  end

  assign rd_valid  = pend;
  assign rd_addr   = addr_q;
  assign load      = slot_end;
  assign load_word = !live ? '0 : got ? hold_q : take ? rd_data : '0;
  assign miss      = slot_end && live && !got && !take;

  // R4
  one_xfer_per_slot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rd_valid && rd_ready |=> !rd_valid);
  // R4
  addr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rd_valid && !rd_ready |=> !rd_valid || $stable(rd_addr));
  // R9
  no_req_idle_slot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !live |-> !rd_valid);

endmodule

// File: rtl/vscan_shift.sv
module vscan_shift #(
  parameter int WORD_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic [WORD_W-1:0] word_in,
  output logic [1:0]        pair
);
  logic [WORD_W-1:0] sh;

  always_ff @(posedge clk) begin
    if (!rst_n)    sh <= '0;
    else if (load) sh <= word_in;
    else           sh <= {sh[WORD_W-3:0], 2'b00};
  end

  assign pair = sh[WORD_W-1 -: 2];
endmodule

// File: rtl/vscan_delay.sv
module vscan_delay #(
  parameter int DEPTH = 8,
  parameter int WIDTH = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] din,
  output logic [WIDTH-1:0] dout
);
  logic [WIDTH-1:0] stage [DEPTH];

  always_ff @(posedge clk) begin
    if (!rst_n) stage[0] <= '0;
    else        stage[0] <= din;
  end

  for (genvar i = 1; i < DEPTH; i++) begin : g_stage
    always_ff @(posedge clk) begin
      if (!rst_n) stage[i] <= '0;
      else        stage[i] <= stage[i-1];
    end
  end

  assign dout = stage[DEPTH-1];
endmodule

// File: rtl/vscan_controller.sv
module vscan_controller #(
  parameter int          WORD_W    = 16,
  parameter int          ADDR_W    = 14,
  parameter int          BASE      = 0,
  parameter int          LFSR_W    = 9,
  parameter logic [15:0] LFSR_TAPS = 16'h0110,
  parameter int          H_TOTAL   = 384,
  parameter int          H_ACTIVE  = 280,
  parameter int          HS_ON     = 296,
  parameter int          HS_OFF    = 342,
  parameter int          V_TOTAL   = 500,
  parameter int          V_ACTIVE  = 455,
  parameter int          VS_ON     = 470,
  parameter int          VS_OFF    = 472
) (
  input  logic              clk,
  input  logic              rst_n,
  output logic              rd_valid,
  input  logic              rd_ready,
  output logic [ADDR_W-1:0] rd_addr,
  input  logic [WORD_W-1:0] rd_data,
  output logic [1:0]        pix_pair,
  output logic              blank,
  output logic              hsync,
  output logic              vsync,
  output logic              underrun
);
  localparam int WORD_CLKS = WORD_W / 2;

  logic              h_wrap, h_act, h_sync, v_wrap, v_act, v_sync;
  logic              load, miss, out_act;
  logic [WORD_W-1:0] load_word;
  logic [1:0]        pair;
  logic [2:0]        dly_out;

  vscan_timer #(.W(LFSR_W), .TAPS(LFSR_TAPS), .TOTAL(H_TOTAL), .ACTIVE(H_ACTIVE),
                .SYNC_ON(HS_ON), .SYNC_OFF(HS_OFF)) u_htimer (
    .clk(clk), .rst_n(rst_n), .adv(1'b1),
    .wrap(h_wrap), .active(h_act), .sync(h_sync));

  vscan_timer #(.W(LFSR_W), .TAPS(LFSR_TAPS), .TOTAL(V_TOTAL), .ACTIVE(V_ACTIVE),
                .SYNC_ON(VS_ON), .SYNC_OFF(VS_OFF)) u_vtimer (
    .clk(clk), .rst_n(rst_n), .adv(h_wrap),
    .wrap(v_wrap), .active(v_act), .sync(v_sync));

  vscan_fetch #(.WORD_W(WORD_W), .ADDR_W(ADDR_W), .BASE(BASE),
                .WORD_CLKS(WORD_CLKS)) u_fetch (
    .clk(clk), .rst_n(rst_n), .line_wrap(h_wrap), .frame_end(v_wrap),
    .fetch_act(h_act && v_act),
    .rd_valid(rd_valid), .rd_ready(rd_ready), .rd_addr(rd_addr), .rd_data(rd_data),
    .load(load), .load_word(load_word), .miss(miss));

  vscan_shift #(.WORD_W(WORD_W)) u_shift (
    .clk(clk), .rst_n(rst_n), .load(load), .word_in(load_word), .pair(pair));

  vscan_delay #(.DEPTH(WORD_CLKS), .WIDTH(3)) u_delay (
    .clk(clk), .rst_n(rst_n), .din({h_act && v_act, h_sync, v_sync}), .dout(dly_out));

  assign out_act = dly_out[2];
  assign hsync   = dly_out[1];
  assign vsync   = dly_out[0];
  assign blank   = !out_act;
  assign pix_pair = out_act ? pair : 2'b00;

  always_ff @(posedge clk) begin
    if (!rst_n)    underrun <= 1'b0;
    else if (miss) underrun <= 1'b1;
  end

  // R8
  underrun_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    underrun |=> underrun);
  // R8
  miss_flags_chk: assert property (@(posedge clk) disable iff (!rst_n)
    miss |=> underrun);

endmodule

// File: tb/test_vscan_controller.sv
module test_vscan_controller;
  localparam int WW = 16, AW = 14, BASE = 256;
  localparam int HT = 48, HA = 32, HS_ON = 36, HS_OFF = 42;
  localparam int VT = 12, VA = 8, VS_ON = 9, VS_OFF = 10;
  localparam int LAG = WW / 2;
  localparam int CYCLES = 3 * HT * VT;
  localparam int SLOW_ADDR = BASE + 5;

  logic          clk = 1'b0;
  logic          rst_n;
  logic          rd_valid, rd_ready;
  logic [AW-1:0] rd_addr;
  logic [WW-1:0] rd_data;
  logic [1:0]    pix_pair;
  logic          blank, hsync, vsync, underrun;

  always #4 clk = ~clk;

  vscan_controller #(.WORD_W(WW), .ADDR_W(AW), .BASE(BASE),
    .H_TOTAL(HT), .H_ACTIVE(HA), .HS_ON(HS_ON), .HS_OFF(HS_OFF),
    .V_TOTAL(VT), .V_ACTIVE(VA), .VS_ON(VS_ON), .VS_OFF(VS_OFF)) i_vscan_controller (
    .clk(clk), .rst_n(rst_n), .rd_valid(rd_valid), .rd_ready(rd_ready),
    .rd_addr(rd_addr), .rd_data(rd_data), .pix_pair(pix_pair), .blank(blank),
    .hsync(hsync), .vsync(vsync), .underrun(underrun));

  typedef struct {
    logic [1:0] pix;
    logic       blank, hs, vs, valid, under;
    int         addr;
    int         t;
  } exp_t;

  exp_t q[$];
  int   n_checks = 0, n_fail = 0;
  bit   done = 0;

  logic [WW-1:0] shown_word = '0, pend_word = '0;
  bit            acked = 0, slot_live = 0, exp_under = 0;

  function automatic logic [WW-1:0] mem(int a);
    return 16'(a * 40503) ^ 16'hC35A;
  endfunction

  task automatic check(string req, string what, int act, int exp, int t);
    n_checks++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s cycle %0d: actual %0d expected %0d", req, what, t, act, exp);
    end
  endtask

  // driver: model one cycle, drive the responder and push the expectation
  task automatic drive_cycle(int t);
    int h, ln, fr, ph, ea, lat, hp, lp;
    exp_t e;
    bit oa;
    h  = t % HT;
    ln = (t / HT) % VT;
    fr = t / (HT * VT);
    ph = h % 8;
    if (ph == 0) begin
      if (slot_live && !acked) exp_under = 1;
      shown_word = pend_word;
      pend_word  = '0;
      acked      = 0;
      slot_live  = (h < HA) && (ln < VA);
    end
    ea = BASE + ln * (HA / 8) + h / 8;
    e.valid = slot_live && ph != 0 && !acked;
    e.addr  = ea;
    lat = (fr == 1 && ea == SLOW_ADDR) ? 9 : ea % 5;
    rd_ready = e.valid && (ph - 1 == lat);
    rd_data  = rd_ready ? mem(ea) : 16'hFFFF;
    if (rd_ready) begin
      pend_word = mem(ea);
      acked     = 1;
    end
    if (t >= LAG) begin
      hp = (t - LAG) % HT;
      lp = ((t - LAG) / HT) % VT;
      oa = (hp < HA) && (lp < VA);
      e.hs = (hp >= HS_ON) && (hp < HS_OFF);
      e.vs = (lp >= VS_ON) && (lp < VS_OFF);
    end else begin
      oa = 0; e.hs = 0; e.vs = 0;
    end
    e.blank = !oa;
    e.pix   = oa ? 2'((shown_word >> (14 - 2 * ph)) & 16'd3) : 2'b00;
    e.under = exp_under;
    e.t     = t;
    q.push_back(e);
  endtask

  // monitor: pop and compare away from the active edge
  always @(negedge clk) begin
    if (q.size() > 0) begin
      exp_t e;
      e = q.pop_front();
      check("R6/R7", "pix_pair", int'(pix_pair), int'(e.pix), e.t);
      check("R7", "blank", int'(blank), int'(e.blank), e.t);
      check("R2", "hsync", int'(hsync), int'(e.hs), e.t);
      check("R3", "vsync", int'(vsync), int'(e.vs), e.t);
      check("R4/R9", "rd_valid", int'(rd_valid), int'(e.valid), e.t);
      if (e.valid) check("R5", "rd_addr", int'(rd_addr), e.addr, e.t);
      check("R8", "underrun", int'(underrun), int'(e.under), e.t);
    end
  end

  initial begin
    rst_n = 1'b0; rd_ready = 1'b0; rd_data = '0;
    repeat (4) @(posedge clk);
    @(negedge clk);
    // R1 reset state while reset is held
    check("R1", "pix_pair", int'(pix_pair), 0, -1);
    check("R1", "blank", int'(blank), 1, -1);
    check("R1", "hsync", int'(hsync), 0, -1);
    check("R1", "vsync", int'(vsync), 0, -1);
    check("R1", "rd_valid", int'(rd_valid), 0, -1);
    check("R1", "underrun", int'(underrun), 0, -1);
    @(posedge clk); #1;
    rst_n = 1'b1;
    for (int t = 0; t < CYCLES; t++) begin
      if (t > 0) begin
        @(posedge clk); #1;
      end
      drive_cycle(t);
    end
    @(negedge clk);
    // R8: the slow slot in frame 1 must have left the flag set
    check("R8", "underrun final", int'(underrun), 1, CYCLES);
    done = 1;
    $display("  [TB] %0d tests run, %0d failed", n_checks, n_fail);
    $finish;
  end

  initial begin
    repeat (CYCLES + 2000) @(posedge clk);
    if (!done) begin
      n_checks++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  [TB] %0d tests run, %0d failed", n_checks, n_fail);
      $finish;
    end
  end
endmodule